// File: doc/BRIEF.md
# Data Access Permission and Fault Status Unit

This unit sits beside a data TLB and turns one load or store request per cycle into either a physical address or a fault code. It receives the virtual address, the request kind and its modifier flags, the processor mode state, the decoded instruction fields and the TLB lookup result. The TLB storage itself is outside the block. The unit then applies, in a fixed order, four stages: the physical bypass, the virtual-address shape check, the kernel-only superpage window, and the per-mode read/write enables with their fault-on-read/fault-on-write traps. A final range check turns an out-of-range physical address into a machine check. Results appear one clock after the request.

When a fault carries a status, three registers capture it: the faulting virtual address, a packed status word, and a page-table pointer formed from a base value and the virtual page number. These registers then freeze. Later faults cannot overwrite them until a read strobe for the address register arrives, so the exception handler always sees the first fault.

Top module: `dacc_perm_unit`

## Requirements
- R1: The effective mode (kernel=0, exec=1, supervisor=2, user=3) is as follows. With `fw_mode` low it is `cur_mode`. With `fw_mode` high it is `alt_mode` when `alt_req` is set, and kernel otherwise. Enable bit i of `tlb_rd_en`/`tlb_wr_en` grants access to mode i.
- R2: The status word is {opcode[5:0], dest_reg[4:0], cause[5:0]}. Cause bits are: 0 store, 1 access violation, 2 fault-on-read, 3 fault-on-write, 4 TLB miss, 5 bad address. Fault codes are 0 none, 1 access violation, 2 fault, 3 miss, 4 page-table miss, 5 machine check.
- R3: A non-physical request is malformed when bits 63:42 of `vaddr` are neither all zero nor all one. It gives code 2 with cause store(if store)|access violation|bad address.
- R4: A TLB miss on a well-formed, non-superpage address gives code 4 when `ptbl_acc` is set and code 3 otherwise. Cause is store(if store)|miss.
- R5: For a store hit, a clear write enable for the effective mode gives code 2 with cause store|access violation, plus fault-on-write when `tlb_fow` is set. If the write enable is set but `tlb_fow` is set, the result is code 2 with cause store|fault-on-write. The read controls are ignored.
- R6: For a load hit, a clear read enable gives code 1 with cause access violation, plus fault-on-read when `tlb_for` is set. If the read enable is set but `tlb_for` is set, the result is code 2 with cause fault-on-read only. The write controls are ignored.
- R7: With `sp_en` set and `vaddr[42:41]`=2, the address maps directly without the TLB. The result is `vaddr[43:0]`, with bits 43:40 forced to one if bit 39 or 40 is set, and to zero otherwise. With `sp_en` clear the TLB path is used.
- R8: A superpage access is allowed only when `cur_mode` is kernel, whatever the effective mode. Otherwise the result is code 1 with cause store(if store)|access violation.
- R9: On a permitted hit, the physical address is {tlb_pfn, vaddr[12:0]}. Any successful translation whose address has a bit at position 44 or above set returns code 5 with that address and records no fault.
- R10: With `phys_req` set, the address passes through unchanged and every other check is skipped except the R9 range check.
- R11: A fault with code 1 to 4, while unlocked, loads `fault_va` with the address and `fault_stat` with the R2 word. It loads `fault_form` with `ptbase | (vaddr[42:13] << 3)`. On any other result these registers keep their values.
- R12: Recording a fault sets a lock that blocks further recording. The lock clears on the clock edge that samples `va_rd`. A fault in the same cycle as `va_rd` is recorded only if the unit was unlocked.
- R13: `rsp_valid` follows `req_valid` one cycle later. With no request, `fcode` and `paddr` are zero.
- R14: After reset, all outputs are zero and the unit is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| vaddr | input | 64 | Virtual address |
| is_store | input | 1 | Store when high, load when low |
| phys_req | input | 1 | Physical bypass request |
| alt_req | input | 1 | Use alternate mode while in firmware mode |
| ptbl_acc | input | 1 | Request is a page-table access |
| cur_mode | input | 2 | Current data mode |
| alt_mode | input | 2 | Alternate mode |
| fw_mode | input | 1 | Firmware mode active |
| sp_en | input | 1 | Superpage window enable |
| opcode | input | 6 | Instruction opcode |
| dest_reg | input | 5 | Destination register number |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_pfn | input | 32 | Frame number from the TLB |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_for | input | 1 | Fault-on-read bit |
| tlb_fow | input | 1 | Fault-on-write bit |
| ptbase | input | 64 | Base for the formatted page-table address |
| va_rd | input | 1 | Read strobe of the fault address register |
| rsp_valid | output | 1 | Result valid |
| paddr | output | 64 | Physical address |
| fcode | output | 3 | Fault code |
| fault_va | output | 64 | Latched faulting address |
| fault_stat | output | 17 | Latched status word |
| fault_form | output | 64 | Latched formatted page-table address |

## Verification
The assertions take two things for granted. First, `va_rd` is a single-cycle strobe whose effect is seen on the next edge. Second, when it arrives without a request the lock must fall. They do not assume that the TLB fields are consistent with one another. So the stimulus drives the enable vectors, the fault bits and the frame number in combinations a real TLB could deliver as well as ones it could not, including the mismatched fault bit of the opposite access kind. Requests are applied back to back, with `va_rd` pulsed both alone and in the same cycle as faults, so that locked and unlocked recording both occur.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    MD_KERN = 2'd0,
    MD_EXEC = 2'd1,
    MD_SUPV = 2'd2,
    MD_USER = 2'd3
  } dmode_e;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_ACV   = 3'd1,
    FC_FLT   = 3'd2,
    FC_MISS  = 3'd3,
    FC_PMISS = 3'd4,
    FC_MCHK  = 3'd5
  } fcode_e;

  localparam int NCAUSE   = 6;
  localparam int CF_WR    = 0;
  localparam int CF_ACV   = 1;
  localparam int CF_FOR   = 2;
  localparam int CF_FOW   = 3;
  localparam int CF_MISS  = 4;
  localparam int CF_BADVA = 5;
endpackage

// File: rtl/dacc_mode_sel.sv
module dacc_mode_sel
  import dacc_pkg::*;
(
  input  logic       fw_mode,
  input  logic       alt_req,
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  output logic [1:0] eff_mode
);
  always_comb begin
    if (fw_mode) eff_mode = alt_req ? alt_mode : MD_KERN;
    else         eff_mode = cur_mode;
  end
endmodule

// File: rtl/dacc_xlate_chk.sv
module dacc_xlate_chk
  import dacc_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_SIG  = 43,
  parameter int PA_IMPL = 44,
  parameter int PG_BITS = 13,
  parameter int PFN_W   = 32,
  parameter int UC_LO   = 39,
  parameter int UC_HI   = 40
) (
  input  logic [VA_W-1:0]   va,
  input  logic              store,
  input  logic              phys,
  input  logic              pte_acc,
  input  logic              sp_en,
  input  logic [1:0]        cur_mode,
  input  logic [1:0]        eff_mode,
  input  logic              hit,
  input  logic [PFN_W-1:0]  pfn,
  input  logic [3:0]        rd_en,
  input  logic [3:0]        wr_en,
  input  logic              f_or,
  input  logic              f_ow,
  output logic [VA_W-1:0]   pa,
  output logic [2:0]        code,
  output logic [NCAUSE-1:0] cause,
  output logic              rec
);
  localparam int PADW = VA_W - PFN_W - PG_BITS;

  logic            va_ok, sp_win;
  logic [VA_W-1:0] sp_pa, hit_pa, cand;
  logic            ok;
  fcode_e          fc;

  assign va_ok  = (va[VA_W-1:VA_SIG-1] == '0) || (va[VA_W-1:VA_SIG-1] == '1);
  assign sp_win = sp_en && (va[VA_SIG-1 -: 2] == 2'b10);
  assign hit_pa = {{PADW{1'b0}}, pfn, va[PG_BITS-1:0]};

  always_comb begin
    sp_pa = va;
    sp_pa[VA_W-1:PA_IMPL] = '0;
    if (sp_pa[UC_LO] || sp_pa[UC_HI]) sp_pa[PA_IMPL-1:UC_HI] = '1;
    else                              sp_pa[PA_IMPL-1:UC_HI] = '0;
  end

  always_comb begin
    fc    = FC_NONE;
    cause = '0;
    cand  = '0;
    ok    = 1'b0;
    pa    = '0;
    if (phys) begin
      cand = va;
      ok   = 1'b1;
    end else if (!va_ok) begin
      fc = FC_FLT;
      cause[CF_WR]    = store;
      cause[CF_ACV]   = 1'b1;
      cause[CF_BADVA] = 1'b1;
    end else if (sp_win) begin
      if (cur_mode != MD_KERN) begin
        fc = FC_ACV;
        cause[CF_WR]  = store;
        cause[CF_ACV] = 1'b1;
      end else begin
        cand = sp_pa;
        ok   = 1'b1;
      end
    end else if (!hit) begin
      fc = pte_acc ? FC_PMISS : FC_MISS;
      cause[CF_WR]   = store;
      cause[CF_MISS] = 1'b1;
    end else if (store) begin
      if (!wr_en[eff_mode]) begin
        fc = FC_FLT;
        cause[CF_WR]  = 1'b1;
        cause[CF_ACV] = 1'b1;
        cause[CF_FOW] = f_ow;
      end else if (f_ow) begin
        fc = FC_FLT;
        cause[CF_WR]  = 1'b1;
        cause[CF_FOW] = 1'b1;
      end else begin
        cand = hit_pa;
        ok   = 1'b1;
      end
    end else begin
      if (!rd_en[eff_mode]) begin
        fc = FC_ACV;
        cause[CF_ACV] = 1'b1;
        cause[CF_FOR] = f_or;
      end else if (f_or) begin
        fc = FC_FLT;
        cause[CF_FOR] = 1'b1;
      end else begin
        cand = hit_pa;
        ok   = 1'b1;
      end
    end
    if (ok) begin
      pa = cand;
      if (|cand[VA_W-1:PA_IMPL]) fc = FC_MCHK;
    end
  end

  assign code = fc;
  assign rec  = (fc != FC_NONE) && (fc != FC_MCHK);
endmodule

// File: rtl/dacc_fault_regs.sv
module dacc_fault_regs #(
  parameter int VA_W    = 64,
  parameter int VA_SIG  = 43,
  parameter int PG_BITS = 13,
  parameter int ST_W    = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rec_req,
  input  logic [VA_W-1:0] va,
  input  logic [ST_W-1:0] stat,
  input  logic [VA_W-1:0] base,
  input  logic            va_rd,
  output logic [VA_W-1:0] fault_va,
  output logic [ST_W-1:0] fault_stat,
  output logic [VA_W-1:0] fault_form,
  output logic            locked
);
  localparam int VPN_W = VA_SIG - PG_BITS;

  logic            take;
  logic [VA_W-1:0] form;

  assign take = rec_req && !locked;
  assign form = base | (VA_W'(va[VA_SIG-1:PG_BITS]) << 3);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_va   <= '0;
      fault_stat <= '0;
      fault_form <= '0;
      locked     <= 1'b0;
    end else if (take) begin
      fault_va   <= va;
      fault_stat <= stat;
      fault_form <= form;
      locked     <= 1'b1;
    end else if (va_rd) begin
      locked     <= 1'b0;
    end
  end
endmodule

// File: rtl/dacc_perm_unit.sv
module dacc_perm_unit #(
  parameter int VA_W    = 64,
  parameter int VA_SIG  = 43,
  parameter int PA_IMPL = 44,
  parameter int PG_BITS = 13,
  parameter int PFN_W   = 32,
  parameter int UC_LO   = 39,
  parameter int UC_HI   = 40,
  parameter int OPC_W   = 6,
  parameter int REG_W   = 5
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  input  logic [VA_W-1:0]                       vaddr,
  input  logic                                  is_store,
  input  logic                                  phys_req,
  input  logic                                  alt_req,
  input  logic                                  ptbl_acc,
  input  logic [1:0]                            cur_mode,
  input  logic [1:0]                            alt_mode,
  input  logic                                  fw_mode,
  input  logic                                  sp_en,
  input  logic [OPC_W-1:0]                      opcode,
  input  logic [REG_W-1:0]                      dest_reg,
  input  logic                                  tlb_hit,
  input  logic [PFN_W-1:0]                      tlb_pfn,
  input  logic [3:0]                            tlb_rd_en,
  input  logic [3:0]                            tlb_wr_en,
  input  logic                                  tlb_for,
  input  logic                                  tlb_fow,
  input  logic [VA_W-1:0]                       ptbase,
  input  logic                                  va_rd,
  output logic                                  rsp_valid,
  output logic [VA_W-1:0]                       paddr,
  output logic [2:0]                            fcode,
  output logic [VA_W-1:0]                       fault_va,
  output logic [OPC_W+REG_W+dacc_pkg::NCAUSE-1:0] fault_stat,
  output logic [VA_W-1:0]                       fault_form
);
  localparam int ST_W = OPC_W + REG_W + dacc_pkg::NCAUSE;

  logic [1:0]                  eff_mode;
  logic [VA_W-1:0]             pa_c;
  logic [2:0]                  code_c;
  logic [dacc_pkg::NCAUSE-1:0] cause_c;
  logic                        rec_c;
  logic                        lock_q;

  dacc_mode_sel mode_i (
    .fw_mode (fw_mode),
    .alt_req (alt_req),
    .cur_mode(cur_mode),
    .alt_mode(alt_mode),
    .eff_mode(eff_mode)
  );

  dacc_xlate_chk #(
    .VA_W(VA_W), .VA_SIG(VA_SIG), .PA_IMPL(PA_IMPL), .PG_BITS(PG_BITS),
    .PFN_W(PFN_W), .UC_LO(UC_LO), .UC_HI(UC_HI)
  ) xl_i (
    .va      (vaddr),
    .store   (is_store),
    .phys    (phys_req),
    .pte_acc (ptbl_acc),
    .sp_en   (sp_en),
    .cur_mode(cur_mode),
    .eff_mode(eff_mode),
    .hit     (tlb_hit),
    .pfn     (tlb_pfn),
    .rd_en   (tlb_rd_en),
    .wr_en   (tlb_wr_en),
    .f_or    (tlb_for),
    .f_ow    (tlb_fow),
    .pa      (pa_c),
    .code    (code_c),
    .cause   (cause_c),
    .rec     (rec_c)
  );

  dacc_fault_regs #(
    .VA_W(VA_W), .VA_SIG(VA_SIG), .PG_BITS(PG_BITS), .ST_W(ST_W)
  ) fr_i (
    .clk       (clk),
    .rst       (rst),
    .rec_req   (req_valid && rec_c),
    .va        (vaddr),
    .stat      ({opcode, dest_reg, cause_c}),
    .base      (ptbase),
    .va_rd     (va_rd),
    .fault_va  (fault_va),
    .fault_stat(fault_stat),
    .fault_form(fault_form),
    .locked    (lock_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      paddr     <= '0;
      fcode     <= '0;
    end else begin
      rsp_valid <= req_valid;
      paddr     <= req_valid ? pa_c : '0;
      fcode     <= req_valid ? code_c : '0;
    end
  end
endmodule

// File: rtl/dacc_perm_unit_chk.sv
module dacc_perm_unit_chk #(
  parameter int VA_W = 64,
  parameter int ST_W = 17
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            va_rd,
  input logic            rsp_valid,
  input logic [2:0]      fcode,
  input logic [VA_W-1:0] fault_va,
  input logic [ST_W-1:0] fault_stat,
  input logic [VA_W-1:0] fault_form,
  input logic            locked
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && fcode == 3'd0)); // R13
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(fault_va) && $stable(fault_stat) && $stable(fault_form))); // R12
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (va_rd && !req_valid) |=> !locked); // R12
  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (rsp_valid && fcode >= 3'd1 && fcode <= 3'd4)); // R11
  AST_MCHK_NOREC: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (fcode == 3'd5 || fcode == 3'd0)) |-> ($stable(fault_va) && $stable(fault_stat))); // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> fcode <= 3'd5); // R2
endmodule

bind dacc_perm_unit dacc_perm_unit_chk #(.VA_W(VA_W), .ST_W(ST_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .va_rd     (va_rd),
  .rsp_valid (rsp_valid),
  .fcode     (fcode),
  .fault_va  (fault_va),
  .fault_stat(fault_stat),
  .fault_form(fault_form),
  .locked    (lock_q)
);

// File: tb/dacc_perm_unit_tb_top.sv
`timescale 1ns/1ps
module dacc_perm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, is_store = 0, phys_req = 0, alt_req = 0, ptbl_acc = 0;
  logic        fw_mode = 0, sp_en = 0, tlb_hit = 0, tlb_for = 0, tlb_fow = 0, va_rd = 0;
  logic [63:0] vaddr = '0, ptbase = 64'hFFFF_F000_0000_0000;
  logic [1:0]  cur_mode = 0, alt_mode = 0;
  logic [5:0]  opcode = 0;
  logic [4:0]  dest_reg = 0;
  logic [31:0] tlb_pfn = 0;
  logic [3:0]  tlb_rd_en = 0, tlb_wr_en = 0;
  logic        rsp_valid;
  logic [63:0] paddr, fault_va, fault_form;
  logic [2:0]  fcode;
  logic [16:0] fault_stat;

  int checks = 0, fails = 0;
  bit done = 0;
  logic        m_lock = 0;
  logic [63:0] m_va = 0, m_form = 0;
  logic [16:0] m_stat = 0;

  always #4 clk = ~clk;

  dacc_perm_unit dut_i (.*);

  task automatic chk(input bit ok, input string rq, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic model(output logic [63:0] pa, output logic [2:0] code, output logic [5:0] cz);
    logic [1:0] eff;
    logic [63:0] t;
    bit ok;
    eff = fw_mode ? (alt_req ? alt_mode : 2'd0) : cur_mode;
    pa = 0; code = 0; cz = 0; ok = 0; t = 0;
    if (phys_req) begin t = vaddr; ok = 1; end
    else if (!((vaddr >> 42) == 0 || (vaddr >> 42) == 64'h3F_FFFF)) begin
      code = 2; cz = 6'b100010 | {5'b0, is_store};
    end else if (sp_en && vaddr[42:41] == 2'b10) begin
      if (cur_mode != 0) begin code = 1; cz = 6'b000010 | {5'b0, is_store}; end
      else begin
        t = vaddr & 64'hFFF_FFFF_FFFF;
        if (t[39] || t[40]) t = t | 64'hF00_0000_0000; else t = t & 64'hFF_FFFF_FFFF;
        ok = 1;
      end
    end else if (!tlb_hit) begin
      code = ptbl_acc ? 3'd4 : 3'd3; cz = 6'b010000 | {5'b0, is_store};
    end else if (is_store) begin
      if (!tlb_wr_en[eff]) begin code = 2; cz = 6'b000011 | (tlb_fow ? 6'b001000 : 6'b0); end
      else if (tlb_fow) begin code = 2; cz = 6'b001001; end
      else begin t = (64'(tlb_pfn) << 13) + 64'(vaddr[12:0]); ok = 1; end
    end else begin
      if (!tlb_rd_en[eff]) begin code = 1; cz = 6'b000010 | (tlb_for ? 6'b000100 : 6'b0); end
      else if (tlb_for) begin code = 2; cz = 6'b000100; end
      else begin t = (64'(tlb_pfn) << 13) + 64'(vaddr[12:0]); ok = 1; end
    end
    if (ok) begin pa = t; if ((t >> 44) != 0) code = 5; end
  endtask

  task automatic go(input string rq);
    logic [63:0] epa;
    logic [2:0]  ec;
    logic [5:0]  ecz;
    bit rec;
    req_valid = 1;
    model(epa, ec, ecz);
    rec = (ec >= 1 && ec <= 4) && !m_lock;
    if (rec) begin
      m_va = vaddr;
      m_stat = {opcode, dest_reg, ecz};
      m_form = ptbase | (64'(vaddr[42:13]) << 3);
    end
    m_lock = rec ? 1'b1 : (va_rd ? 1'b0 : m_lock);
    @(negedge clk);
    chk(rsp_valid && fcode == ec && paddr == epa, rq, {rsp_valid, fcode, paddr}, {1'b1, ec, epa});
    chk(fault_va == m_va && fault_stat == m_stat && fault_form == m_form, "R11 R12",
        {fault_va, fault_stat, fault_form[63:0]}, {m_va, m_stat, m_form[63:0]});
    req_valid = 0;
    va_rd = 0;
  endtask

  task automatic rd_pulse();
    va_rd = 1;
    m_lock = 0;
    @(negedge clk);
    va_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    k = 0;
    repeat (4) @(negedge clk);
    chk(!rsp_valid && paddr == 0 && fcode == 0 && fault_va == 0 && fault_stat == 0 && fault_form == 0,
        "R14", {rsp_valid, fcode, paddr}, 0);
    rst = 0;
    @(negedge clk);
    chk(!rsp_valid && fcode == 0 && paddr == 0, "R13", {rsp_valid, fcode, paddr}, 0);

    // R1 R5 R6 R9: mode selection and permission sweep
    for (int fw = 0; fw < 2; fw++)
      for (int af = 0; af < 2; af++)
        for (int cm = 0; cm < 4; cm++)
          for (int am = 0; am < 4; am++)
            for (int st = 0; st < 2; st++)
              for (int en = 0; en < 2; en++)
                for (int fo = 0; fo < 2; fo++) begin
                  logic [1:0] e;
                  logic [3:0] oh;
                  fw_mode = fw[0]; alt_req = af[0]; cur_mode = cm[1:0]; alt_mode = am[1:0];
                  e = fw[0] ? (af[0] ? am[1:0] : 2'd0) : cm[1:0];
                  oh = 4'b0001 << e;
                  tlb_rd_en = en[0] ? oh : ~oh;
                  tlb_wr_en = en[0] ? oh : ~oh;
                  is_store = st[0];
                  tlb_fow = st[0] ? fo[0] : !fo[0];
                  tlb_for = st[0] ? !fo[0] : fo[0];
                  tlb_hit = 1; phys_req = 0; ptbl_acc = k[1]; sp_en = k[0];
                  vaddr = (64'(k) * 64'h3_5A7B_1D5) & 64'h1FF_FFFF_FFFF;
                  tlb_pfn = 32'(k) * 32'h9E37_79B1;
                  opcode = k[5:0]; dest_reg = k[6:2];
                  va_rd = (k % 3 == 0);
                  go(st ? "R1 R5 R9" : "R1 R6 R9");
                  k++;
                end

    // R3 malformed addresses, R10 bypass of the same
    for (int p = 0; p < 4; p++)
      for (int st = 0; st < 2; st++)
        for (int ph = 0; ph < 2; ph++) begin
          case (p)
            0: vaddr = 64'h0000_0400_0000_0123;
            1: vaddr = 64'h8000_0000_0000_0000;
            2: vaddr = 64'h0000_0FFF_FFFF_F000;
            default: vaddr = 64'hFFFF_F800_0000_4567;
          endcase
          is_store = st[0]; phys_req = ph[0]; tlb_hit = 1; sp_en = 0;
          fw_mode = 0; cur_mode = 0; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;
          tlb_for = 0; tlb_fow = 0; tlb_pfn = 32'h0000_1234;
          opcode = 6'h2A; dest_reg = 5'(p + st);
          go(ph ? "R10" : "R3 R2");
          rd_pulse();
        end

    // R4 misses
    for (int pt = 0; pt < 2; pt++)
      for (int st = 0; st < 2; st++) begin
        phys_req = 0; tlb_hit = 0; ptbl_acc = pt[0]; is_store = st[0];
        vaddr = 64'h0000_0123_4567_8000 + 64'(pt * 2 + st);
        opcode = 6'h11; dest_reg = 5'h1F;
        go("R4");
        rd_pulse();
      end

    // R7 R8 superpage window
    for (int b = 0; b < 4; b++)
      for (int cm = 0; cm < 4; cm++)
        for (int fw = 0; fw < 2; fw++)
          for (int sp = 0; sp < 2; sp++) begin
            vaddr = 64'hFFFF_FC00_0000_0000 | (64'(b) << 39) | 64'h1_2345_6789;
            cur_mode = cm[1:0]; fw_mode = fw[0]; alt_req = 1; alt_mode = 0;
            sp_en = sp[0]; phys_req = 0; tlb_hit = 1;
            tlb_rd_en = 0; tlb_wr_en = 0; is_store = b[0];
            tlb_for = 0; tlb_fow = 0;
            va_rd = 1;
            go("R7 R8");
          end

    // R9 directed machine check on a hit
    phys_req = 0; sp_en = 0; fw_mode = 0; cur_mode = 3; is_store = 0;
    tlb_hit = 1; tlb_rd_en = 4'b1000; tlb_for = 0; tlb_pfn = 32'h8000_0001;
    vaddr = 64'h0000_0000_0000_1ABC;
    go("R9");

    // R10 in-range bypass
    phys_req = 1; vaddr = 64'h0000_0ABC_DEF0_1234;
    go("R10");

    // R12 lock sequence
    rd_pulse();
    phys_req = 0; tlb_hit = 0; ptbl_acc = 0; is_store = 0;
    vaddr = 64'h0000_0000_0AAA_A000; go("R12");
    vaddr = 64'h0000_0000_0BBB_B000; go("R12");
    vaddr = 64'h0000_0000_0CCC_C000; va_rd = 1; go("R12");
    vaddr = 64'h0000_0000_0DDD_D000; go("R12");
    rd_pulse();
    vaddr = 64'h0000_0000_0EEE_E000; va_rd = 1; go("R12");
    vaddr = 64'h0000_0000_0FFF_F000; go("R12");

    @(negedge clk);
    chk(!rsp_valid && fcode == 0 && paddr == 0, "R13", {rsp_valid, fcode, paddr}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule